// File: doc/BRIEF.md
# Pulse Accumulator with Timer Clock Selection

This block is a 16-bit pulse accumulator for a microcontroller-style timer. It has two modes. In edge-count mode each selected transition of an external pin adds one to the count. In gated mode the count advances on a divide-by-64 tick from the timer prescaler, but only while the pin sits at the selected level. A single polarity bit picks the edge in the first mode and the gating level in the second.

Two sticky flags are kept. The pin flag marks the active pin transition. In gated mode that transition is the trailing edge of the gate. The overflow flag marks a wrap of the count. Each flag has its own interrupt enable, and each is cleared by a one-cycle strobe. The block also produces the clock enable for the main timer counter. A 2-bit selector chooses the prescaler tick, the accumulator tick, or a carry out of the count at /256 or /65536. Register access and the main counter itself are outside this block.

Top module: `pulse_accum`

## Requirements
- R1: While rstN is low and in the first cycle after it goes high, count is 0, both flags are 0 and both interrupt outputs are 0.
- R2: With accEn low, count and both flags never change except through their clear strobes, whatever pinIn, polarity, gateMode or div64Tick do.
- R3: pinIn passes through two synchronizing flops, and an edge is found by comparing the second flop with its value one cycle earlier. A pin change first sampled at clock edge k is counted (count updated) at edge k+2.
- R4: In edge-count mode (gateMode=0), polarity=0 adds one per falling pin edge and polarity=1 adds one per rising pin edge.
- R5: In gated mode (gateMode=1), each cycle with div64Tick=1 and timerEn=1 adds one when the synchronized pin is high (polarity=0) or low (polarity=1). With timerEn=0 the count does not advance in gated mode.
- R6: With accEn high, pinFlag is set by a falling synchronized edge when polarity=0 and by a rising one when polarity=1, in both modes. In gated mode this is the trailing edge of the gate.
- R7: ovfFlag is set when an increment takes count from 16'hFFFF to 16'h0000.
- R8: A high pinClr or ovfClr clears its flag at the next edge. If a set and a clear of the same flag meet in one cycle, the flag is set.
- R9: ovfIrq is high exactly when ovfIntEn and ovfFlag are both high. pinIrq is high exactly when pinIntEn and pinFlag are both high.
- R10: cntClkEn follows clkSel in the same cycle. 2'b00 gives prescTick. 2'b01 gives the accumulator tick. 2'b10 gives the tick only when count[7:0] is 8'hFF. 2'b11 gives the tick only when count is 16'hFFFF.
- R11: With accEn low, cntClkEn equals prescTick for every clkSel value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| accEn | input | 1 | Accumulator enable |
| gateMode | input | 1 | 0 edge-count mode, 1 gated mode |
| polarity | input | 1 | Edge or gate-level select |
| clkSel | input | 2 | Timer counter clock source select |
| timerEn | input | 1 | Timer running; needed for gated ticks |
| prescTick | input | 1 | Timer prescaler tick |
| div64Tick | input | 1 | Bus clock /64 tick from the prescaler |
| pinIn | input | 1 | Asynchronous accumulator pin |
| ovfIntEn | input | 1 | Overflow interrupt enable |
| pinIntEn | input | 1 | Pin interrupt enable |
| ovfClr | input | 1 | Overflow flag clear strobe |
| pinClr | input | 1 | Pin flag clear strobe |
| count | output | 16 | Accumulator count |
| ovfFlag | output | 1 | Overflow flag |
| pinFlag | output | 1 | Pin edge flag |
| ovfIrq | output | 1 | Overflow interrupt request |
| pinIrq | output | 1 | Pin interrupt request |
| cntClkEn | output | 1 | Clock enable for the main timer counter |

## Verification
The assertions assume that every input except pinIn is synchronous to clk. They also assume that reset is not asserted again in the middle of a run, so any jump of count other than +1 counts as a fault. The stimulus changes every input only on the falling clock edge. It holds reset long enough for the synchronizer to flush. A directed run with the gate held open drives count through the full 16-bit range, so the /256 and /65536 carries and the wrap are reached without touching the counter directly.

// File: rtl/pulse_accum_pkg.sv
package pulse_accum_pkg;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic accTick;  // add one to the count this cycle
    logic pinEdge;  // active pin transition seen this cycle
  } accStrobe_t;

  typedef enum logic [1:0] {
    CS_PRESC    = 2'b00,
    CS_ACC      = 2'b01,
    CS_ACC_LO   = 2'b10,
    CS_ACC_FULL = 2'b11
  } clkSrc_e;

endpackage

// File: rtl/pulse_accum_ctrl.sv
module pulse_accum_ctrl
  import pulse_accum_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       accEn,
  input  logic       gateMode,
  input  logic       polarity,
  input  logic       timerEn,
  input  logic       div64Tick,
  input  logic       pinIn,
  output accStrobe_t strobe
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] syncQ;
  logic              pinPrev;
  logic              pinNow;
  logic              riseEdge;
  logic              fallEdge;
  logic              activeEdge;
  logic              gateOpen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      pinPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_MSB-1:0], pinIn};
      pinPrev <= syncQ[SYNC_MSB];
    end
  end

  assign pinNow   = syncQ[SYNC_MSB];
  assign riseEdge = pinNow & ~pinPrev;
  assign fallEdge = ~pinNow & pinPrev;

  // The edge that is counted in edge mode is also the gate's trailing edge.
  assign activeEdge = polarity ? riseEdge : fallEdge;
  // Gate open on high level for polarity 0, low level for polarity 1.
  assign gateOpen   = pinNow ^ polarity;

  always_comb begin
    strobe.pinEdge = accEn & activeEdge;
    if (gateMode) strobe.accTick = accEn & gateOpen & timerEn & div64Tick;
    else          strobe.accTick = accEn & activeEdge;
  end

endmodule

// File: rtl/pulse_accum_flag.sv
module pulse_accum_flag (
  input  logic clk,
  input  logic rstN,
  input  logic setP,
  input  logic clrP,
  input  logic intEn,
  output logic flag,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rstN)     flag <= 1'b0;
    else if (setP) flag <= 1'b1;
    else if (clrP) flag <= 1'b0;
  end

  assign irq = intEn & flag;

endmodule

// File: rtl/pulse_accum_dp.sv
module pulse_accum_dp
  import pulse_accum_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accEn,
  input  logic [1:0]       clkSel,
  input  logic             prescTick,
  input  accStrobe_t       strobe,
  output logic [CNT_W-1:0] count,
  output logic             wrapP,
  output logic             cntClkEn
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [LOW_W-1:0] LOW_MAX = '1;

  logic lowCarry;
  logic fullCarry;

  always_ff @(posedge clk) begin
    if (!rstN)               count <= '0;
    else if (strobe.accTick) count <= count + 1'b1;
  end

  assign lowCarry  = strobe.accTick & (count[LOW_W-1:0] == LOW_MAX);
  assign fullCarry = strobe.accTick & (count == CNT_MAX);
  assign wrapP     = fullCarry;

  always_comb begin
    if (!accEn) begin
      cntClkEn = prescTick;
    end else begin
      case (clkSrc_e'(clkSel))
        CS_ACC:      cntClkEn = strobe.accTick;
        CS_ACC_LO:   cntClkEn = lowCarry;
        CS_ACC_FULL: cntClkEn = fullCarry;
        default:     cntClkEn = prescTick;
      endcase
    end
  end

endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pulse_accum_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int LOW_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accEn,
  input  logic             gateMode,
  input  logic             polarity,
  input  logic [1:0]       clkSel,
  input  logic             timerEn,
  input  logic             prescTick,
  input  logic             div64Tick,
  input  logic             pinIn,
  input  logic             ovfIntEn,
  input  logic             pinIntEn,
  input  logic             ovfClr,
  input  logic             pinClr,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag,
  output logic             pinFlag,
  output logic             ovfIrq,
  output logic             pinIrq,
  output logic             cntClkEn
);

  accStrobe_t strobe;
  logic       wrapP;

  pulse_accum_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .accEn(accEn), .gateMode(gateMode),
    .polarity(polarity), .timerEn(timerEn), .div64Tick(div64Tick),
    .pinIn(pinIn), .strobe(strobe)
  );

  pulse_accum_dp #(.CNT_W(CNT_W), .LOW_W(LOW_W)) dp_i (
    .clk(clk), .rstN(rstN), .accEn(accEn), .clkSel(clkSel),
    .prescTick(prescTick), .strobe(strobe), .count(count),
    .wrapP(wrapP), .cntClkEn(cntClkEn)
  );

  pulse_accum_flag ovfFlag_i (
    .clk(clk), .rstN(rstN), .setP(wrapP), .clrP(ovfClr),
    .intEn(ovfIntEn), .flag(ovfFlag), .irq(ovfIrq)
  );

  pulse_accum_flag pinFlag_i (
    .clk(clk), .rstN(rstN), .setP(strobe.pinEdge), .clrP(pinClr),
    .intEn(pinIntEn), .flag(pinFlag), .irq(pinIrq)
  );

endmodule

// File: rtl/pulse_accum_chk.sv
module pulse_accum_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             accEn,
  input logic             gateMode,
  input logic             timerEn,
  input logic             prescTick,
  input logic [CNT_W-1:0] count,
  input logic             ovfFlag,
  input logic             pinFlag,
  input logic             ovfIrq,
  input logic             pinIrq,
  input logic             ovfIntEn,
  input logic             pinIntEn,
  input logic             ovfClr,
  input logic             pinClr,
  input logic             cntClkEn
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2: a disabled accumulator keeps its count
  a_r2_hold_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !accEn |=> $stable(count));

  // R4: the count only ever steps by one
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(count) |-> count == $past(count) + 1'b1);

  // R5: gated mode without a running timer does not advance
  a_r5_gate_needs_timer: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && gateMode && !timerEn) |=> $stable(count));

  // R7: a wrap raises the overflow flag
  a_r7_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rstN)
    ($past(count) == CNT_MAX && count == '0) |-> ovfFlag);

  // R8: a clear with no wrap empties the overflow flag
  a_r8_ovf_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ovfClr && count != CNT_MAX) |=> !ovfFlag);

  // R9: requests need their flag and their enable
  a_r9_ovf_irq: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |-> (ovfFlag && ovfIntEn));
  a_r9_pin_irq: assert property (@(posedge clk) disable iff (!rstN)
    pinIrq |-> (pinFlag && pinIntEn));

  // R11: disabled accumulator passes the prescaler tick
  a_r11_presc_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !accEn |-> cntClkEn == prescTick);

endmodule

bind pulse_accum pulse_accum_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/pulse_accum_tb.sv
module pulse_accum_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        accEn, gateMode, polarity, timerEn, prescTick, div64Tick, pinIn;
  logic        ovfIntEn, pinIntEn, ovfClr, pinClr;
  logic [1:0]  clkSel;
  logic [15:0] count;
  logic        ovfFlag, pinFlag, ovfIrq, pinIrq, cntClkEn;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // model state
  logic        ms1 = 0, ms2 = 0, msp = 0;
  logic [15:0] mCnt = 0;
  logic        mOvf = 0, mPin = 0;

  always #2 clk = ~clk;

  pulse_accum dut_i (
    .clk(clk), .rstN(rstN), .accEn(accEn), .gateMode(gateMode),
    .polarity(polarity), .clkSel(clkSel), .timerEn(timerEn),
    .prescTick(prescTick), .div64Tick(div64Tick), .pinIn(pinIn),
    .ovfIntEn(ovfIntEn), .pinIntEn(pinIntEn), .ovfClr(ovfClr),
    .pinClr(pinClr), .count(count), .ovfFlag(ovfFlag), .pinFlag(pinFlag),
    .ovfIrq(ovfIrq), .pinIrq(pinIrq), .cntClkEn(cntClkEn)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic edgeHit();
    return polarity ? (ms2 & ~msp) : (~ms2 & msp);
  endfunction

  function automatic logic expTick();
    if (!accEn) return 1'b0;
    if (gateMode) return timerEn & div64Tick & (ms2 ^ polarity);
    return edgeHit();
  endfunction

  function automatic logic expClk();
    logic t;
    t = expTick();
    if (!accEn) return prescTick;
    case (clkSel)
      2'b00: return prescTick;
      2'b01: return t;
      2'b10: return t & (mCnt[7:0] == 8'hFF);
      default: return t & (mCnt == 16'hFFFF);
    endcase
  endfunction

  // inputs are already applied; compare then advance the model one edge
  task automatic step();
    logic t, pe;
    #1;
    check("R3/R4/R5 count", count, mCnt);
    check("R7 ovfFlag", ovfFlag, mOvf);
    check("R6/R8 pinFlag", pinFlag, mPin);
    check("R9 ovfIrq", ovfIrq, ovfIntEn & mOvf);
    check("R9 pinIrq", pinIrq, pinIntEn & mPin);
    check(accEn ? "R10 cntClkEn" : "R11 cntClkEn", cntClkEn, expClk());
    t  = expTick();
    pe = accEn & edgeHit();
    if (t && mCnt == 16'hFFFF) mOvf = 1'b1;
    else if (ovfClr)           mOvf = 1'b0;
    if (pe)          mPin = 1'b1;
    else if (pinClr) mPin = 1'b0;
    if (t) mCnt = mCnt + 16'd1;
    msp = ms2; ms2 = ms1; ms1 = pinIn;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 0; accEn = 0; gateMode = 0; polarity = 0; clkSel = 0; timerEn = 0;
    prescTick = 0; div64Tick = 0; pinIn = 0; ovfIntEn = 0; pinIntEn = 0;
    ovfClr = 0; pinClr = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    #1;
    check("R1 count", count, 0);
    check("R1 ovfFlag", ovfFlag, 0);
    check("R1 pinFlag", pinFlag, 0);
    check("R1 irqs", {ovfIrq, pinIrq}, 0);
    @(negedge clk);
    rstN = 1;
    ovfIntEn = 1; pinIntEn = 1;
    step();
    check("R1 count after release", count, 0);

    // R2: disabled, pin toggles and ticks ignored
    for (int i = 0; i < 40; i++) begin
      pinIn = ~pinIn; div64Tick = 1; timerEn = 1; gateMode = i[3];
      polarity = i[2]; prescTick = i[0]; clkSel = 2'(i);
      step();
    end
    check("R2 count held", count, 0);

    // R3/R4: directed falling edge, polarity 0 edge mode
    accEn = 1; gateMode = 0; polarity = 0; pinIn = 1; div64Tick = 0;
    repeat (4) step();
    pinIn = 0; step(); step();
    check("R3 not yet counted", count, mCnt);
    step();

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 64) == 0) gateMode = $urandom % 2;
      if (($urandom % 96) == 0) polarity = $urandom % 2;
      accEn     = ($urandom % 8) != 0;
      timerEn   = ($urandom % 6) != 0;
      div64Tick = ($urandom % 3) == 0;
      prescTick = $urandom % 2;
      if (($urandom % 4) == 0) pinIn = ~pinIn;
      clkSel    = 2'($urandom % 4);
      ovfClr    = ($urandom % 16) == 0;
      pinClr    = ($urandom % 12) == 0;
      ovfIntEn  = ($urandom % 4) != 0;
      pinIntEn  = ($urandom % 4) != 0;
      step();
    end

    // R7/R8/R10: gate held open through a full wrap, clear at the wrap cycle
    accEn = 1; gateMode = 1; polarity = 0; timerEn = 1; div64Tick = 1;
    pinIn = 1; pinClr = 0; ovfClr = 1;
    repeat (3) step();
    ovfClr = 0;
    for (int i = 0; i < 65560; i++) begin
      clkSel = 2'($urandom % 4);
      ovfClr = (mCnt == 16'hFFFF);  // R8: set beats clear
      step();
    end
    check("R8 set wins over clear", ovfFlag, 1);

    // R5/R6: trailing edge of gate sets pinFlag, timerEn=0 freezes
    ovfClr = 0; pinClr = 1; step(); pinClr = 0;
    pinIn = 0; repeat (3) step();
    check("R6 trailing edge flag", pinFlag, 1);
    timerEn = 0; polarity = 1; repeat (10) step();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule